// File: doc/BRIEF.md
# Self-Starting Synchronous Reset Generator

This block produces a clean reset for the logic around it without any dedicated reset pin. A short fill register comes out of configuration holding all zeros and takes in one more '1' on every clock. Reset is requested while any of its bits is still zero. The requested reset then passes through a final flip-flop, and that flip-flop drives the output.

Two inputs can empty the fill register again. The first is a pushbutton: while it is held, the register stays empty. The second is a slide switch: any change in its level, in either direction, empties the register once, so each flip of the switch gives exactly one reset pulse. Both inputs first pass through a two-flop synchroniser. The switch level is compared with a copy of itself delayed by one clock. All of these flops power up to the same level, so configuration itself does not look like a switch flip. The whole block runs on one clock and has no asynchronous behaviour.

Top module: `boot_reset_gen`

## Requirements
- R1: After configuration, `rst_o` is 1 before the first clock edge. It stays 1 through the first N clock edges and drops to 0 at edge N+1, where N = STRETCH_LEN (default 4).
- R2: While `button_i` is 0 and `switch_i` keeps its level, a `rst_o` that is 0 stays 0.
- R3: Each reset pulse started by a single switch change lasts exactly N clock cycles. `rst_o` drops at the (N+1)th edge after the last edge that emptied the fill register.
- R4: If a change of `switch_i` (0 to 1 or 1 to 0) is first sampled at edge e, `rst_o` becomes 1 after edge e+3. It remains 1 through edge e+N+2 and is 0 after edge e+N+3.
- R5: A second change of `switch_i` while a pulse is in progress restarts the count. For a flip at edge e followed by a flip back at edge e+2, `rst_o` is 1 after edges e+3 through e+N+4.
- R6: `button_i` is active high. If it is sampled 1 at edges e through e+H-1 and 0 at edge e+H, then `rst_o` is 1 after edges e+3 through e+H+N+1 and 0 after edge e+H+N+2.
- R7: `rst_o` is driven directly by a flip-flop. The switch synchroniser and its delayed copy power up at SW_INIT (default 0), so a switch that sits at SW_INIT from configuration adds no reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for every flop in the block |
| button_i | input | 1 | Pushbutton, active high, asynchronous to clk |
| switch_i | input | 1 | Slide switch level, asynchronous to clk |
| rst_o | output | 1 | Registered reset, active high |

## Verification
The hardest cases are the exact edges where each pulse starts and ends. If the output flop were missing, or a synchroniser stage were miscounted, every pulse would shift by one cycle, and the window checks would flag it. A detector that looks at only one direction of the switch would miss the falling flip. If the delayed copy did not restart the count, a quick double flip would give a pulse that is too short. A design that ignored a held button after its first cycle would release reset while the button is still down. Long quiet stretches with the switch held steady confirm that no extra reset pulses appear.

// File: rtl/boot_reset_pkg.sv
package boot_reset_pkg;

    // two synchroniser stages, first and second
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_pair_t;

    // delayed copy of a synchronised level
    typedef struct packed {
        logic prev;
    } edge_state_t;

    // registered output stage of the generator
    typedef struct packed {
        logic rst;
    } out_state_t;

endpackage

// File: rtl/boot_reset_sync2.sv
module boot_reset_sync2
    import boot_reset_pkg::*;
#(
    parameter logic INIT_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic d_i,
    output logic q_o
);

    sync_pair_t sync_d;
    sync_pair_t sync_q = {INIT_LEVEL, INIT_LEVEL};

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = d_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk) begin
        sync_q <= sync_d;
    end

    assign q_o = sync_q.s2;

endmodule

// File: rtl/boot_reset_change.sv
module boot_reset_change
    import boot_reset_pkg::*;
#(
    parameter logic INIT_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic level_i,
    output logic changed_o
);

    edge_state_t edge_d;
    edge_state_t edge_q = INIT_LEVEL;

    always_comb begin
        edge_d      = edge_q;
        edge_d.prev = level_i;
    end

    always_ff @(posedge clk) begin
        edge_q <= edge_d;
    end

    // any difference from the one-clock-old copy is a flip, either way
    assign changed_o = level_i ^ edge_q.prev;

endmodule

// File: rtl/boot_reset_stretch.sv
module boot_reset_stretch #(
    parameter int unsigned STAGES = 4
) (
    input  logic clk,
    input  logic clear_i,
    output logic hold_o
);

    typedef struct packed {
        logic [STAGES-1:0] fill;
    } fill_state_t;

    fill_state_t fill_d;
    fill_state_t fill_q = '0;   // empty after configuration
    logic [STAGES-1:0] shifted;

    generate
        if (STAGES == 1) begin : g_single
            assign shifted = 1'b1;
        end else begin : g_shift
            assign shifted = {fill_q.fill[STAGES-2:0], 1'b1};
        end
    endgenerate

    always_comb begin
        fill_d      = fill_q;
        fill_d.fill = clear_i ? '0 : shifted;
    end

    always_ff @(posedge clk) begin
        fill_q <= fill_d;
    end

    // request reset while any stage is still empty
    assign hold_o = ~&fill_q.fill;

endmodule

// File: rtl/boot_reset_gen.sv
module boot_reset_gen
    import boot_reset_pkg::*;
#(
    parameter int unsigned STRETCH_LEN = 4,
    parameter logic        SW_INIT     = 1'b0
) (
    input  logic clk,
    input  logic button_i,
    input  logic switch_i,
    output logic rst_o
);

    localparam int unsigned FILL_W = (STRETCH_LEN < 1) ? 1 : STRETCH_LEN;

    logic btn_sync;
    logic sw_sync;
    logic sw_flip;
    logic clear_req;
    logic hold_req;

    boot_reset_sync2 #(.INIT_LEVEL(1'b0)) i_btn_sync (
        .clk (clk),
        .d_i (button_i),
        .q_o (btn_sync)
    );

    boot_reset_sync2 #(.INIT_LEVEL(SW_INIT)) i_sw_sync (
        .clk (clk),
        .d_i (switch_i),
        .q_o (sw_sync)
    );

    boot_reset_change #(.INIT_LEVEL(SW_INIT)) i_sw_change (
        .clk       (clk),
        .level_i   (sw_sync),
        .changed_o (sw_flip)
    );

    assign clear_req = btn_sync | sw_flip;

    boot_reset_stretch #(.STAGES(FILL_W)) i_stretch (
        .clk     (clk),
        .clear_i (clear_req),
        .hold_o  (hold_req)
    );

    out_state_t out_d;
    out_state_t out_q = 1'b1;   // reset asserted from configuration

    always_comb begin
        out_d     = out_q;
        out_d.rst = hold_req;
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign rst_o = out_q.rst;

endmodule

// File: rtl/boot_reset_gen_chk.sv
module boot_reset_gen_chk #(
    parameter int unsigned STRETCH_LEN = 4,
    parameter logic        SW_INIT     = 1'b0
) (
    input logic clk,
    input logic button_i,
    input logic switch_i,
    input logic rst_o
);

    logic [3:0] warm_q  = '0;
    logic [7:0] hi_q    = '0;
    logic [7:0] quiet_q = '0;
    logic       swp_q   = SW_INIT;
    logic       ready;

    assign ready = (warm_q >= 4'd6);

    always_ff @(posedge clk) begin
        if (!ready) warm_q <= warm_q + 4'd1;
        hi_q    <= rst_o ? ((hi_q == 8'hFF) ? hi_q : hi_q + 8'd1) : 8'd0;
        quiet_q <= (button_i || (switch_i != swp_q)) ? 8'd0
                 : ((quiet_q == 8'hFF) ? quiet_q : quiet_q + 8'd1);
        swp_q   <= switch_i;
    end

    // R4: a switch flip shows up as reset four samples later
    a_r4_switch_pulse: assert property (@(posedge clk) disable iff (!ready)
        ($past(switch_i, 4) != $past(switch_i, 5)) |-> rst_o);

    // R6: a sampled button press holds reset four samples later
    a_r6_button_hold: assert property (@(posedge clk) disable iff (!ready)
        $past(button_i, 4) |-> rst_o);

    // R3: no pulse shorter than the stretch length
    a_r3_min_width: assert property (@(posedge clk) disable iff (!ready)
        $fell(rst_o) |-> (hi_q >= 8'(STRETCH_LEN)));

    // R2: quiet inputs keep a released reset released
    a_r2_quiet_low: assert property (@(posedge clk) disable iff (!ready)
        ((quiet_q >= 8'd5) && !rst_o) |=> !rst_o);

endmodule

bind boot_reset_gen boot_reset_gen_chk #(
    .STRETCH_LEN (STRETCH_LEN),
    .SW_INIT     (SW_INIT)
) i_chk (
    .clk      (clk),
    .button_i (button_i),
    .switch_i (switch_i),
    .rst_o    (rst_o)
);

// File: tb/test_boot_reset_gen.sv
module test_boot_reset_gen;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int WIN        = 24;

    typedef struct packed {
        bit is_btn;
        int hold;
        int first_hi;
        int last_hi;
    } vec_t;

    // samples j = 0.. are taken after edge e+j; expected high for first..last
    localparam vec_t VECS [5] = '{
        '{1'b0, 0,  3, N + 2},       // R4 switch rising
        '{1'b0, 0,  3, N + 2},       // R4 switch falling
        '{1'b1, 1,  3, 1 + N + 1},   // R6 one-cycle press
        '{1'b1, 3,  3, 3 + N + 1},   // R6
        '{1'b1, 10, 3, 10 + N + 1}   // R6 long hold
    };

    logic clk = 1'b0;
    logic button_i = 1'b0;
    logic switch_i = 1'b0;
    logic rst_o;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    boot_reset_gen #(.STRETCH_LEN(N)) i_boot_reset_gen (
        .clk      (clk),
        .button_i (button_i),
        .switch_i (switch_i),
        .rst_o    (rst_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input logic exp, input string req, input int idx);
        n_checks++;
        if (rst_o !== exp) begin
            n_errors++;
            $display("FAIL %s sample %0d: rst_o=%b expected %b", req, idx, rst_o, exp);
        end
    endtask

    initial begin
        #1;
        check(1'b1, "R1", 0);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            check((k <= N) ? 1'b1 : 1'b0, "R1", k);   // R7 no extra pulse either
        end

        // table of vectors
        for (int v = 0; v < 5; v++) begin
            repeat (10) @(negedge clk);
            if (VECS[v].is_btn) button_i = 1'b1;
            else                switch_i = ~switch_i;
            for (int j = 0; j < WIN; j++) begin
                @(negedge clk);
                check((j >= VECS[v].first_hi && j <= VECS[v].last_hi) ? 1'b1 : 1'b0,
                      VECS[v].is_btn ? "R6" : "R4_R3", j);
                if (VECS[v].is_btn && j == VECS[v].hold - 1) button_i = 1'b0;
            end
        end

        // R5: flip and flip back two edges later
        repeat (10) @(negedge clk);
        switch_i = ~switch_i;
        for (int j = 0; j < WIN; j++) begin
            @(negedge clk);
            check((j >= 3 && j <= N + 4) ? 1'b1 : 1'b0, "R5", j);
            if (j == 1) switch_i = ~switch_i;
        end

        // R2: steady inputs, reset stays low
        for (int j = 0; j < 30; j++) begin
            @(negedge clk);
            check(1'b0, "R2", j);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule